// File: doc/BRIEF.md
# Codec register access controller

This block runs one register access at a time, read or write, to an external audio codec that is reached over a framed serial link. The host issues a 32-bit command word. The word carries a read/write flag, a 7-bit codec register address and 16 bits of write data. The block holds that word until the next frame boundary. During the following frame it drives the outgoing command-address and command-data slots, and it marks both slots valid in their tag bits.

A write is complete when the frame that carried it ends. A read goes on waiting after that frame until a later incoming frame reports a valid status-address slot. The block then takes the 16-bit data field of the status-data slot and places it in the low half of the readback word. When either kind of access completes, the block raises a level interrupt. The host can wait on that interrupt before it reads the result. Frame timing, serialization and tag assembly belong to neighbouring blocks.

The controller has four states:
- `ST_IDLE`: no access is pending.
- `ST_ARMED`: a command is held, waiting for a frame boundary.
- `ST_SEND`: the current frame carries the command.
- `ST_WAIT_RESP`: a read waits for its status.

It has five transitions:
- IDLE→ARMED when a command is accepted.
- ARMED→SEND on a frame boundary.
- SEND→IDLE on the next boundary for a write.
- SEND→WAIT_RESP on that boundary for a read.
- WAIT_RESP→IDLE when a status strobe arrives with its address tag valid.

Top module: `crac_ctrl`

## Requirements
- R1: After reset the block is idle: `busy`, `irq`, both outgoing tags, both outgoing slots and `cmd_rdata` are all zero.
- R2: An accepted command (`cmd_wr` while idle) sets `busy` at once, but leaves both tags low until a `frame_start` pulse arrives. This holds even when `frame_start` comes in the same cycle as `cmd_wr`.
- R3: While the command is sent, the command-address slot carries the read flag (command bit 31) in slot bit 19 and the address (command bits [22:16]) in slot bits [18:12]. Slot bits [11:0] are zero.
- R4: While the command is sent, the command-data slot carries the write data (command bits [15:0]) in slot bits [19:4] for a write. For a read it is all zero.
- R5: Both tags are high for exactly the one frame after the boundary that follows acceptance. Outside that frame they are low.
- R6: A write completes at the `frame_start` that ends its sending frame. On that edge `busy` falls and `irq` rises.
- R7: A read stays busy after its sending frame. A status strobe whose address tag is low, or a strobe that arrives during the sending frame, does not complete it.
- R8: A read completes on a status strobe with the tag high. `cmd_rdata[15:0]` then takes the strobed data (status slot bits [19:4]), and `cmd_rdata[31:16]` keeps the issued command's upper half.
- R9: `cmd_wr` while busy is ignored: `cmd_rdata` and the slot contents keep the pending command.
- R10: `irq` stays high after completion until the next accepted command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command issue strobe |
| cmd_wdata | input | 32 | Command word: [31] read flag, [22:16] address, [15:0] write data |
| cmd_rdata | output | 32 | Readback: held command, low half replaced by read data |
| busy | output | 1 | Access pending |
| irq | output | 1 | Completion interrupt, level |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| tx_addr_tag | output | 1 | Valid tag for the outgoing command-address slot |
| tx_data_tag | output | 1 | Valid tag for the outgoing command-data slot |
| tx_addr_slot | output | 20 | Outgoing command-address slot |
| tx_data_slot | output | 20 | Outgoing command-data slot |
| rx_stat_stb | input | 1 | Pulse when an incoming frame's status slots are available |
| rx_stat_tag | input | 1 | Valid tag of the incoming status-address slot |
| rx_stat_data | input | 16 | Bits [19:4] of the incoming status-data slot |

## Verification
The bench builds the block with its default parameters: a 32-bit command word, a 7-bit address, 16-bit data and 20-bit slots. With these values the exact bit positions of R3, R4 and R8 can be checked with literal slot values. Those values include the largest address, 7'h7F, which fills slot bits [18:12] completely. Frame boundaries and status strobes are single pulses placed by hand. This lets the bench place a boundary in the same cycle as a command, put a status strobe inside the sending frame, and hold a read in its wait state across untagged strobes.

// File: rtl/crac_pkg.sv
package crac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_ARMED     = 2'd1,
        ST_SEND      = 2'd2,
        ST_WAIT_RESP = 2'd3
    } crac_state_e;

endpackage

// File: rtl/crac_fsm.sv
module crac_fsm
    import crac_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic        frame_start,
    input  logic        is_read,
    input  logic        rx_stat_stb,
    input  logic        rx_stat_tag,
    output crac_state_e state,
    output logic        load_cmd,
    output logic        rd_done,
    output logic        sending,
    output logic        busy,
    output logic        irq
);

    crac_state_e state_nx;
    logic        wr_done;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (cmd_wr)      state_nx = ST_ARMED;
            ST_ARMED:     if (frame_start) state_nx = ST_SEND;
            ST_SEND:      if (frame_start) state_nx = is_read ? ST_WAIT_RESP : ST_IDLE;
            ST_WAIT_RESP: if (rx_stat_stb && rx_stat_tag) state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // outputs decoded from the state
    always_comb begin
        load_cmd = 1'b0;
        rd_done  = 1'b0;
        wr_done  = 1'b0;
        sending  = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy     = 1'b0;
                load_cmd = cmd_wr;
            end
            ST_ARMED: ;
            ST_SEND: begin
                sending = 1'b1;
                wr_done = frame_start && !is_read;
            end
            ST_WAIT_RESP: rd_done = rx_stat_stb && rx_stat_tag;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                irq <= 1'b0;
        else if (load_cmd)         irq <= 1'b0;
        else if (rd_done || wr_done) irq <= 1'b1;
    end

    assert_hold_until_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED && !frame_start) |=> (state == ST_ARMED));

    assert_write_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && frame_start && !is_read) |=> (state == ST_IDLE && irq));

    assert_read_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_RESP && !(rx_stat_stb && rx_stat_tag)) |=> (state == ST_WAIT_RESP && !irq));

    assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !irq);

endmodule

// File: rtl/crac_cmd_reg.sv
module crac_cmd_reg #(
    parameter int CMD_W  = 32,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              rd_done,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              sending,
    output logic              is_read,
    output logic [CMD_W-1:0]  readback,
    output logic              addr_tag,
    output logic              data_tag,
    output logic [SLOT_W-1:0] addr_slot,
    output logic [SLOT_W-1:0] data_slot
);

    localparam int RD_BIT   = CMD_W - 1;
    localparam int ADDR_LO  = DATA_W;
    localparam int ADDR_PAD = SLOT_W - 1 - ADDR_W;
    localparam int DATA_PAD = SLOT_W - DATA_W;

    logic [CMD_W-1:0]  cmd_q;
    logic [ADDR_W-1:0] addr_f;
    logic [DATA_W-1:0] wdata_f;

    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_q <= '0;
        else if (load)    cmd_q <= cmd_word;
        else if (rd_done) cmd_q[DATA_W-1:0] <= rd_data;
    end

    assign is_read  = cmd_q[RD_BIT];
    assign addr_f   = cmd_q[ADDR_LO +: ADDR_W];
    assign wdata_f  = cmd_q[DATA_W-1:0];
    assign readback = cmd_q;

    // slots are driven only in the frame that carries the command
    assign addr_tag  = sending;
    assign data_tag  = sending;
    assign addr_slot = sending ? {is_read, addr_f, {ADDR_PAD{1'b0}}} : '0;
    assign data_slot = (sending && !is_read) ? {wdata_f, {DATA_PAD{1'b0}}} : '0;

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (readback[DATA_W-1:0] == $past(rd_data)));

    assert_read_data_slot_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_tag && is_read) |-> (data_slot == '0));

endmodule

// File: rtl/crac_ctrl.sv
module crac_ctrl
    import crac_pkg::*;
#(
    parameter int CMD_W  = 32,
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16,
    parameter int SLOT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_wdata,
    output logic [CMD_W-1:0]  cmd_rdata,
    output logic              busy,
    output logic              irq,
    input  logic              frame_start,
    output logic              tx_addr_tag,
    output logic              tx_data_tag,
    output logic [SLOT_W-1:0] tx_addr_slot,
    output logic [SLOT_W-1:0] tx_data_slot,
    input  logic              rx_stat_stb,
    input  logic              rx_stat_tag,
    input  logic [DATA_W-1:0] rx_stat_data
);

    crac_state_e state;
    logic        load_cmd;
    logic        rd_done;
    logic        sending;
    logic        is_read;

    crac_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .frame_start (frame_start),
        .is_read     (is_read),
        .rx_stat_stb (rx_stat_stb),
        .rx_stat_tag (rx_stat_tag),
        .state       (state),
        .load_cmd    (load_cmd),
        .rd_done     (rd_done),
        .sending     (sending),
        .busy        (busy),
        .irq         (irq)
    );

    crac_cmd_reg #(
        .CMD_W  (CMD_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SLOT_W (SLOT_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_cmd),
        .cmd_word  (cmd_wdata),
        .rd_done   (rd_done),
        .rd_data   (rx_stat_data),
        .sending   (sending),
        .is_read   (is_read),
        .readback  (cmd_rdata),
        .addr_tag  (tx_addr_tag),
        .data_tag  (tx_data_tag),
        .addr_slot (tx_addr_slot),
        .data_slot (tx_data_slot)
    );

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !rd_done) |=> $stable(cmd_rdata));

    assert_tags_need_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_addr_tag || tx_data_tag) |-> (busy && state == ST_SEND));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tx_addr_tag && tx_addr_slot == '0 && tx_data_slot == '0));

endmodule

// File: tb/sim_crac_ctrl.sv
module sim_crac_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        busy, irq;
    logic        frame_start = 1'b0;
    logic        tx_addr_tag, tx_data_tag;
    logic [19:0] tx_addr_slot, tx_data_slot;
    logic        rx_stat_stb = 1'b0;
    logic        rx_stat_tag = 1'b0;
    logic [15:0] rx_stat_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    crac_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .busy(busy), .irq(irq), .frame_start(frame_start),
        .tx_addr_tag(tx_addr_tag), .tx_data_tag(tx_data_tag),
        .tx_addr_slot(tx_addr_slot), .tx_data_slot(tx_data_slot),
        .rx_stat_stb(rx_stat_stb), .rx_stat_tag(rx_stat_tag), .rx_stat_data(rx_stat_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [31:0] w);
        cmd_wr = 1'b1; cmd_wdata = w;
        step();
        cmd_wr = 1'b0;
    endtask

    task automatic frame;
        frame_start = 1'b1;
        step();
        frame_start = 1'b0;
    endtask

    task automatic status(input logic tag, input logic [15:0] d);
        rx_stat_stb = 1'b1; rx_stat_tag = tag; rx_stat_data = d;
        step();
        rx_stat_stb = 1'b0; rx_stat_tag = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 tags", {30'd0, tx_addr_tag, tx_data_tag}, 32'd0);
        chk("R1 slots", {12'd0, tx_addr_slot | tx_data_slot}, 32'd0);
        chk("R1 rdata", cmd_rdata, 32'd0);
    endtask

    task automatic t_write;
        issue(32'h002A_BEEF);
        chk("R2 busy after accept", {31'd0, busy}, 32'd1);
        chk("R2 tags held", {30'd0, tx_addr_tag, tx_data_tag}, 32'd0);
        step(); step();
        chk("R2 tags still held", {30'd0, tx_addr_tag, tx_data_tag}, 32'd0);
        frame();
        chk("R5 tags in frame", {30'd0, tx_addr_tag, tx_data_tag}, 32'd3);
        chk("R3 addr slot write", {12'd0, tx_addr_slot}, 32'h0002_A000);
        chk("R4 data slot write", {12'd0, tx_data_slot}, 32'h000B_EEF0);
        status(1'b1, 16'h5555);
        chk("R7 strobe in send frame ignored", {30'd0, busy, irq}, 32'd2);
        frame();
        chk("R6 write done", {30'd0, busy, irq}, 32'd1);
        chk("R5 tags after frame", {30'd0, tx_addr_tag, tx_data_tag}, 32'd0);
        chk("R8 rdata after write", cmd_rdata, 32'h002A_BEEF);
        step(); step();
        chk("R10 irq stays", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_read;
        issue(32'h8005_1234);
        chk("R10 irq cleared", {31'd0, irq}, 32'd0);
        frame();
        chk("R3 addr slot read", {12'd0, tx_addr_slot}, 32'h0008_5000);
        chk("R4 data slot read", {12'd0, tx_data_slot}, 32'd0);
        frame();
        chk("R5 tags off while waiting", {30'd0, tx_addr_tag, tx_data_tag}, 32'd0);
        chk("R7 busy after send", {30'd0, busy, irq}, 32'd2);
        status(1'b0, 16'hABCD);
        chk("R7 untagged ignored", {30'd0, busy, irq}, 32'd2);
        chk("R7 rdata untouched", cmd_rdata, 32'h8005_1234);
        status(1'b1, 16'h9876);
        chk("R8 read done", {30'd0, busy, irq}, 32'd1);
        chk("R8 rdata", cmd_rdata, 32'h8005_9876);
    endtask

    task automatic t_busy_ignore;
        issue(32'h0011_0001);
        issue(32'h807F_5555);
        chk("R9 rdata kept", cmd_rdata, 32'h0011_0001);
        frame();
        issue(32'h807F_5555);
        chk("R9 addr slot kept", {12'd0, tx_addr_slot}, 32'h0001_1000);
        chk("R9 data slot kept", {12'd0, tx_data_slot}, 32'h0000_0010);
        frame();
        chk("R6 write done 2", {30'd0, busy, irq}, 32'd1);
    endtask

    task automatic t_same_cycle;
        cmd_wr = 1'b1; cmd_wdata = 32'h807F_0000; frame_start = 1'b1;
        step();
        cmd_wr = 1'b0; frame_start = 1'b0;
        chk("R2 same-cycle boundary held", {29'd0, busy, tx_addr_tag, tx_data_tag}, 32'd4);
        frame();
        chk("R3 max address slot", {12'd0, tx_addr_slot}, 32'h000F_F000);
        frame();
        status(1'b1, 16'hFFFF);
        chk("R8 full read data", cmd_rdata, 32'h807F_FFFF);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_write();
        t_read();
        t_busy_ignore();
        t_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule